// File: doc/BRIEF.md
# Rotating Current-Source Calibration Scheduler

This block sequences the recalibration of the coarse current sources in a segmented current-steering converter. The converter has one more physical source slot than it has coarse logical positions. At any moment one slot is connected to the shared reference for calibration, and every other slot drives exactly one logical position. Conversion therefore carries on without a gap while the sources are refreshed in turn, round after round.

Each step has two phases. First the selected slot is held in calibration by a one-hot enable until the analog cell returns a done pulse, and the slot is then marked calibrated. Second, the scheduler waits for the tick interval to run out. It then hands that freshly calibrated slot the single logical position that the next slot in turn was serving, and takes that next slot out of service for calibration. The slot calibrated most recently is also named as the source for the fine binary divider path.

Top module: `cs_cal_rotator`

## Requirements
- R1: While reset is held, the slot under calibration is the highest-numbered slot (index N_POS). Its enable bit is set, logical position p maps to slot p for every p, no slot is marked calibrated, and the divider source is marked not ready.
- R2: The calibrate enable is a one-hot vector with bit i meaning slot i. It equals the bit of the current calibration slot from an advance (or reset) until a done pulse is accepted, and it is all zeros from then until the next advance.
- R3: A done pulse sampled while the enable is active marks that slot calibrated on the same clock edge. A done pulse sampled while the enable is all zeros leaves the enable, the calibrated flags and the calibration slot unchanged.
- R4: A time counter restarts at every advance and at reset. An advance happens on the first edge at which calibration has finished and at least tick_period edges have passed since the previous advance. When done comes early enough, consecutive advances are therefore exactly tick_period cycles apart (for tick_period of 2 or more).
- R5: At each advance the calibration slot steps from c to c+1, and from the highest slot it wraps to slot 0.
- R6: At an advance, the one logical position served by the incoming slot is handed to the outgoing, calibrated slot, and every other logical position keeps its slot. Mappings never change except at an advance.
- R7: No logical position ever maps to the slot under calibration, and each other slot serves exactly one logical position.
- R8: A slot loses its calibrated flag on the advance that puts it into calibration, so a slot under calibration is never flagged calibrated.
- R9: The divider source index is the slot whose done pulse was accepted most recently. Its ready flag rises with the first accepted done, and that slot is always flagged calibrated.
- R10: If calibration takes longer than the tick interval, the advance waits for it. The advance then comes one edge after the done pulse is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_period | input | TW | Minimum number of cycles between advances |
| cal_done | input | 1 | Done pulse from the analog calibration cell |
| cal_en | output | N_POS+1 | One-hot calibrate enable, bit i for slot i |
| cal_idx | output | SW | Index of the slot currently out of service |
| pos_map | output | N_POS*SW | Slot index for each logical position, position p in bits [p*SW +: SW] |
| slot_ok | output | N_POS+1 | Per-slot calibrated flags |
| div_idx | output | SW | Slot routed to the binary divider path |
| div_ok | output | 1 | Divider source holds a calibrated slot |

## Verification
The bench builds the block with four logical positions (five slots) and an 8-bit tick period. A full rotation then takes only five advances, so the wrap from the top slot back to slot 0 and the walk of logical positions across slots happen several times within a few hundred cycles. The runs mix short and long calibration delays against tick periods of 3 to 20 cycles. This covers both advances paced by the timer and advances held back by calibration, and one hold window is long enough to inject a stray done pulse.

// File: rtl/cs_rot_pkg.sv
package cs_rot_pkg;

  typedef enum logic {
    PH_CAL  = 1'b0,
    PH_HOLD = 1'b1
  } phase_t;

  // successor of a slot index in a ring of n slots
  function automatic int unsigned ring_next(int unsigned cur, int unsigned n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/cs_tick_timer.sv
module cs_tick_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [TW-1:0] period,
  output logic          due
);
  logic [TW-1:0] cnt_q;
  logic [TW:0]   elapsed;

  // edges seen since the last restart, counting the coming one
  assign elapsed = {1'b0, cnt_q} + (TW+1)'(1);
  assign due     = elapsed >= {1'b0, period};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (restart)           cnt_q <= '0;
    else if (cnt_q != {TW{1'b1}}) cnt_q <= cnt_q + TW'(1);
  end

  AST_TIMER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0)); // R4

endmodule

// File: rtl/cs_phase_ctl.sv
module cs_phase_ctl
  import cs_rot_pkg::*;
#(
  parameter int N_SLOT = 33,
  parameter int SW     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cal_done,
  input  logic              due,
  output logic              adv,
  output logic              done_acc,
  output logic [SW-1:0]     cal_idx,
  output logic [SW-1:0]     nxt_idx,
  output logic [N_SLOT-1:0] cal_en,
  output logic [N_SLOT-1:0] slot_ok,
  output logic [SW-1:0]     div_idx,
  output logic              div_ok
);
  phase_t            phase_q;
  logic [SW-1:0]     cal_q;
  logic [N_SLOT-1:0] ok_q;
  logic [SW-1:0]     div_q;
  logic              div_ok_q;

  // named events for the checks below
  assign done_acc = (phase_q == PH_CAL)  && cal_done;
  assign adv      = (phase_q == PH_HOLD) && due;
  assign nxt_idx  = SW'(ring_next(32'(cal_q), N_SLOT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_CAL;
      cal_q    <= SW'(N_SLOT - 1);
      div_q    <= '0;
      div_ok_q <= 1'b0;
    end else begin
      if (done_acc) begin
        phase_q  <= PH_HOLD;
        div_q    <= cal_q;
        div_ok_q <= 1'b1;
      end
      if (adv) begin
        phase_q <= PH_CAL;
        cal_q   <= nxt_idx;
      end
    end
  end

  for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            ok_q[g] <= 1'b0;
      else if (done_acc && cal_q == SW'(g))  ok_q[g] <= 1'b1;
      else if (adv && nxt_idx == SW'(g))     ok_q[g] <= 1'b0;
    end
    assign cal_en[g] = (phase_q == PH_CAL) && (cal_q == SW'(g));
  end

  assign cal_idx = cal_q;
  assign slot_ok = ok_q;
  assign div_idx = div_q;
  assign div_ok  = div_ok_q;

  AST_EN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cal_en)); // R2
  AST_DONE_DROPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    done_acc |=> (cal_en == '0) && slot_ok[cal_idx]); // R3
  AST_CAL_NOT_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_en & slot_ok) == '0); // R8
  AST_HANDOVER_OK: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> slot_ok[cal_idx]); // R6
  AST_NO_ADV_IN_CAL: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_en != '0) |-> !adv); // R10
  AST_STEP_RING: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (cal_idx == $past(nxt_idx)) && (cal_en != '0)); // R5
  AST_DIV_OK: assert property (@(posedge clk) disable iff (!rst_n)
    div_ok |-> slot_ok[div_idx]); // R9

endmodule

// File: rtl/cs_slot_map.sv
module cs_slot_map #(
  parameter int N_POS  = 32,
  parameter int N_SLOT = 33,
  parameter int SW     = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv,
  input  logic [SW-1:0]       out_idx,
  input  logic [SW-1:0]       in_idx,
  output logic [N_POS*SW-1:0] map_flat
);
  logic [SW-1:0]    map_q [N_POS];
  logic [N_POS-1:0] hit;

  for (genvar p = 0; p < N_POS; p++) begin : g_pos
    // this position is served by the slot about to leave service
    assign hit[p] = (map_q[p] == in_idx);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            map_q[p] <= SW'(p);
      else if (adv && hit[p]) map_q[p] <= out_idx;
    end

    assign map_flat[p*SW +: SW] = map_q[p];

    AST_MAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(map_q[p])); // R6
  end

  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> ($countones(hit) == 1)); // R7

endmodule

// File: rtl/cs_cal_rotator.sv
module cs_cal_rotator #(
  parameter int N_POS = 32,
  parameter int TW    = 16,
  localparam int N_SLOT = N_POS + 1,
  localparam int SW     = $clog2(N_SLOT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [TW-1:0]       tick_period,
  input  logic                cal_done,
  output logic [N_SLOT-1:0]   cal_en,
  output logic [SW-1:0]       cal_idx,
  output logic [N_POS*SW-1:0] pos_map,
  output logic [N_SLOT-1:0]   slot_ok,
  output logic [SW-1:0]       div_idx,
  output logic                div_ok
);
  logic          adv;
  logic          done_acc;
  logic          due;
  logic [SW-1:0] nxt_idx;

  cs_tick_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (adv),
    .period  (tick_period),
    .due     (due)
  );

  cs_phase_ctl #(.N_SLOT(N_SLOT), .SW(SW)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cal_done (cal_done),
    .due      (due),
    .adv      (adv),
    .done_acc (done_acc),
    .cal_idx  (cal_idx),
    .nxt_idx  (nxt_idx),
    .cal_en   (cal_en),
    .slot_ok  (slot_ok),
    .div_idx  (div_idx),
    .div_ok   (div_ok)
  );

  cs_slot_map #(.N_POS(N_POS), .N_SLOT(N_SLOT), .SW(SW)) u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .out_idx  (cal_idx),
    .in_idx   (nxt_idx),
    .map_flat (pos_map)
  );

  // a logical position fed by the slot under calibration
  logic [N_POS-1:0] clash;
  for (genvar p = 0; p < N_POS; p++) begin : g_clash
    assign clash[p] = (pos_map[p*SW +: SW] == cal_idx);
  end

  AST_NO_CAL_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    clash == '0); // R7
  AST_DONE_THEN_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    done_acc |=> div_ok && (div_idx == cal_idx)); // R9

endmodule

// File: tb/sim_cs_cal_rotator.sv
module sim_cs_cal_rotator;
  localparam int NP = 4;
  localparam int NS = NP + 1;
  localparam int SW = $clog2(NS);
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [TW-1:0] tick_period = TW'(6);
  logic          done_resp = 1'b0;
  logic          done_stray = 1'b0;
  logic          cal_done;
  logic [NS-1:0]    cal_en;
  logic [SW-1:0]    cal_idx;
  logic [NP*SW-1:0] pos_map;
  logic [NS-1:0]    slot_ok;
  logic [SW-1:0]    div_idx;
  logic             div_ok;

  assign cal_done = done_resp | done_stray;

  always #2 clk = ~clk;

  cs_cal_rotator #(.N_POS(NP), .TW(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_period(tick_period), .cal_done(cal_done),
    .cal_en(cal_en), .cal_idx(cal_idx), .pos_map(pos_map), .slot_ok(slot_ok),
    .div_idx(div_idx), .div_ok(div_ok)
  );

  int n_chk = 0;
  int n_bad = 0;
  int resp_d = 2;

  typedef struct {
    int    gap;
    int    nxt;
    int    lp;
    int    old;
    string rq;
  } exp_t;
  exp_t q[$];

  int owner [NS];
  int b_cal;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int map_at(int p);
    return int'(pos_map[p*SW +: SW]);
  endfunction

  // scoreboard driver: model the rotation through a slot->position table
  task automatic push_steps(int n, int gap, string rq);
    for (int k = 0; k < n; k++) begin
      exp_t e;
      int nx;
      nx = (b_cal == NS - 1) ? 0 : b_cal + 1;
      e.nxt = nx;
      e.lp  = owner[nx];
      e.old = b_cal;
      e.gap = (k == 0) ? 0 : gap;
      e.rq  = rq;
      owner[b_cal] = owner[nx];
      owner[nx] = -1;
      b_cal = nx;
      q.push_back(e);
    end
  endtask

  task automatic run_phase(int p, int d, int n, string rq);
    while (q.size() != 0) @(negedge clk);
    tick_period = TW'(p);
    resp_d = d;
    push_steps(n, (p > d + 1) ? p : d + 1, rq);
  endtask

  // calibration cell model: done after resp_d cycles of enable
  initial begin
    int rc;
    rc = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        done_resp = 1'b0;
        rc = 0;
      end else if (cal_en != '0 && !done_resp) begin
        rc++;
        if (rc >= resp_d) begin
          done_resp = 1'b1;
          rc = 0;
        end
      end else begin
        done_resp = 1'b0;
      end
    end
  end

  // monitor: pop expected advances and compare
  initial begin
    int prev_cal;
    int prev_map [NP];
    int cyc;
    int last_adv;
    prev_cal = NS - 1;
    for (int p = 0; p < NP; p++) prev_map[p] = p;
    cyc = 0;
    last_adv = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        int cur;
        int cnt [NS];
        bit perm;
        cyc++;
        cur = int'(cal_idx);
        if (cur != prev_cal) begin
          if (q.size() == 0) begin
            chk(1'b0, "R5 unexpected advance", cur, -1);
          end else begin
            exp_t e;
            int moved;
            e = q.pop_front();
            chk(cur == e.nxt, "R5 next slot", cur, e.nxt);
            chk(map_at(e.lp) == e.old, "R6 handed position", map_at(e.lp), e.old);
            moved = 0;
            for (int p = 0; p < NP; p++)
              if (p != e.lp && map_at(p) != prev_map[p]) moved++;
            chk(moved == 0, "R6 other positions kept", moved, 0);
            chk(slot_ok[cur] == 1'b0, "R8 incoming flag cleared", int'(slot_ok[cur]), 0);
            chk(slot_ok[e.old] == 1'b1, "R3 outgoing calibrated", int'(slot_ok[e.old]), 1);
            chk(div_ok && int'(div_idx) == e.old, "R9 divider source", int'(div_idx), e.old);
            chk(cal_en == (NS'(1) << cur), "R2 enable on new slot", int'(cal_en), 1 << cur);
            if (e.gap > 0)
              chk(cyc - last_adv == e.gap, e.rq, cyc - last_adv, e.gap);
          end
          last_adv = cyc;
        end else begin
          int moved;
          moved = 0;
          for (int p = 0; p < NP; p++)
            if (map_at(p) != prev_map[p]) moved++;
          if (moved != 0) chk(1'b0, "R6 map moved without advance", moved, 0);
        end
        for (int s = 0; s < NS; s++) cnt[s] = 0;
        for (int p = 0; p < NP; p++) cnt[map_at(p)]++;
        perm = (cnt[cur] == 0);
        for (int s = 0; s < NS; s++) if (s != cur && cnt[s] != 1) perm = 1'b0;
        chk(perm, "R7 permutation without calibrating slot", cnt[cur], 0);
        prev_cal = cur;
        for (int p = 0; p < NP; p++) prev_map[p] = map_at(p);
      end
    end
  end

  task automatic stray_probe();
    logic [NS-1:0] ok0;
    logic [SW-1:0] ci0;
    @(negedge clk);
    while (cal_en != '0) @(negedge clk);
    ok0 = slot_ok;
    ci0 = cal_idx;
    done_stray = 1'b1;
    @(negedge clk);
    done_stray = 1'b0;
    chk(cal_en == '0, "R3 stray done keeps enable low", int'(cal_en), 0);
    chk(slot_ok == ok0, "R3 stray done keeps flags", int'(slot_ok), int'(ok0));
    chk(cal_idx == ci0, "R3 stray done keeps slot", int'(cal_idx), int'(ci0));
  endtask

  initial begin
    for (int s = 0; s < NS; s++) owner[s] = (s < NP) ? s : -1;
    b_cal = NS - 1;
    fork
      begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(int'(cal_idx) == NS - 1, "R1 reset slot", int'(cal_idx), NS - 1);
        chk(cal_en == (NS'(1) << (NS - 1)), "R1 reset enable", int'(cal_en), 1 << (NS - 1));
        chk(slot_ok == '0, "R1 no slot calibrated", int'(slot_ok), 0);
        chk(div_ok == 1'b0, "R1 divider not ready", int'(div_ok), 0);
        for (int p = 0; p < NP; p++)
          chk(map_at(p) == p, "R1 identity map", map_at(p), p);
        run_phase(6, 2, 7, "R4 timer paced gap");
        rst_n = 1'b1;
        run_phase(5, 1, 6, "R4 timer paced gap");
        run_phase(3, 4, 6, "R10 calibration paced gap");
        run_phase(4, 15, 3, "R10 long calibration gap");
        run_phase(20, 2, 2, "R4 long period gap");
        stray_probe();
        run_phase(6, 2, 3, "R4 timer paced gap");
        while (q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
      end
      begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule